// File: doc/BRIEF.md
# PWM Interrupt Status and Clear

This block gathers the interrupt events of one PWM generator and turns them into a single interrupt request for an interrupt controller. Six single-cycle event strobes come in from the generator: counter at zero, counter at load, and an up-count match and a down-count match for each of two comparators. Each strobe sets a sticky raw bit. A six-bit enable mask selects which raw bits reach the masked status. The interrupt line is the OR of the masked status.

Software reaches the block through a plain register port. It reads the masked status, the raw status and the enable mask, writes the enable mask, and clears events by writing ones to the status offset. A clear that arrives before one PWM clock period has passed since the event is held back. It is applied at the next PWM clock-enable tick. Because of this, clear latency grows with the PWM clock divider.

Top module: `pwm_irq_status`

## Requirements
- R1: After reset the raw status, the enable mask and the masked status all read 0, and `irq` is 0.
- R2: An event strobe on bit i sets raw bit i on the next clock edge. The bit stays set whatever the enable mask holds. The bit order is: 0 counter zero, 1 counter load, 2 comparator A up, 3 comparator A down, 4 comparator B up, 5 comparator B down.
- R3: A masked status bit reads 1 exactly when its raw bit and its enable bit are both 1. Reads return the masked status at offset 0x04C + 0x40*GEN, the raw status at that offset minus 4, and the enable mask at that offset minus 8. Bits 31 to 6 read 0, and any other offset reads 0.
- R4: `irq` is 1 exactly when at least one masked status bit is 1.
- R5: A write to the status offset clears the raw bit, and with it the masked bit, at each position written with 1. Positions written with 0 are unchanged. The clear takes effect on the same edge once a PWM tick has occurred after the event that set the bit.
- R6: A clear written before any PWM tick has followed the event is held pending. The bit stays 1 until the edge of the next cycle with `pwm_tick` high, and is cleared on that edge.
- R7: When an event strobe and a clear of the same bit meet on one edge, the bit stays 1, and any pending clear of it is dropped.
- R8: A write to the enable offset stores `wdata[5:0]`. A write to the raw-status offset has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwm_tick | input | 1 | PWM clock-enable tick, one cycle per PWM clock |
| evt | input | 6 | Event strobes, one bit per source |
| wr_en | input | 1 | Register write strobe |
| addr | input | 12 | Register byte offset, used for reads and writes |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq | output | 1 | Combined interrupt request |

## Verification
Every register update lands on the clock edge where its strobe, write or tick is sampled. `rdata` and `irq` are combinational from the registers, so they show that update one edge after the stimulus. A clear that must wait shows on the edge of the first tick cycle that follows the event. The bench drives inputs on the falling edge and updates its model at the rising edge. It compares `irq` and `rdata` at the next falling edge, which is the first point where each result is due. Directed sequences add literal expectations for the pending-clear, set-wins and ignored-write cases.

// File: rtl/pwm_irq_status.sv
module pwm_irq_status #(
  parameter int GEN = 0,
  parameter int AW  = 12,
  parameter int DW  = 32,
  parameter int NEV = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pwm_tick,
  input  logic [NEV-1:0] evt,
  input  logic           wr_en,
  input  logic [AW-1:0]  addr,
  input  logic [DW-1:0]  wdata,
  output logic [DW-1:0]  rdata,
  output logic           irq
);
  localparam logic [AW-1:0] STAT_OFS = AW'(12'h04C + GEN * 12'h040);
  localparam logic [AW-1:0] RAW_OFS  = STAT_OFS - AW'(4);
  localparam logic [AW-1:0] EN_OFS   = STAT_OFS - AW'(8);

  logic [NEV-1:0] raw, en, armed, pend;
  logic [NEV-1:0] req, fire, stat;

  assign req  = (wr_en && addr == STAT_OFS) ? wdata[NEV-1:0] : '0;
  assign fire = (req | pend) & (armed | {NEV{pwm_tick}});
  assign stat = raw & en;
  assign irq  = |stat;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raw   <= '0;
      en    <= '0;
      armed <= '0;
      pend  <= '0;
    end else begin
      raw   <= evt | (raw & ~fire);
      pend  <= ~evt & raw & (req | pend) & ~fire;
      armed <= ~evt & (armed | {NEV{pwm_tick}});
      if (wr_en && addr == EN_OFS) en <= wdata[NEV-1:0];
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      STAT_OFS: rdata[NEV-1:0] = stat;
      RAW_OFS:  rdata[NEV-1:0] = raw;
      EN_OFS:   rdata[NEV-1:0] = en;
      default:  rdata = '0;
    endcase
  end

  a_r2_event_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> ((raw & $past(evt)) == $past(evt)));

  a_r5_clear_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
    ((~raw & $past(raw) & ~($past(req) | $past(pend))) == '0));

  a_r6_no_early_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ((~raw & $past(raw) & ~($past(armed) | {NEV{$past(pwm_tick)}})) == '0));

  a_r8_enable_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == EN_OFS) |=> (en == $past(wdata[NEV-1:0])));
endmodule

// File: tb/sim_pwm_irq_status.sv
module sim_pwm_irq_status;
  localparam logic [11:0] ST = 12'h04C, RW = 12'h048, EN = 12'h044;

  logic clk = 0, rst_n = 0, pwm_tick = 0, wr_en = 0;
  logic [5:0] evt = '0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic irq;

  int errors = 0, checks = 0;
  bit m_raw[6], m_arm[6], m_pend[6];
  logic [5:0] m_en = '0;

  pwm_irq_status u0 (.clk, .rst_n, .pwm_tick, .evt, .wr_en, .addr, .wdata, .rdata, .irq);

  always #5 clk = ~clk;

  function automatic logic [5:0] raw_vec();
    logic [5:0] v;
    for (int i = 0; i < 6; i++) v[i] = m_raw[i];
    return v;
  endfunction

  function automatic logic [31:0] exp_read(input logic [11:0] a);
    if (a == ST) return {26'd0, raw_vec() & m_en};
    if (a == RW) return {26'd0, raw_vec()};
    if (a == EN) return {26'd0, m_en};
    return 32'd0;
  endfunction

  task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic model_update();
    bit req;
    for (int i = 0; i < 6; i++) begin
      req = wr_en && addr == ST && wdata[i];
      if (evt[i]) begin
        m_raw[i] = 1; m_arm[i] = 0; m_pend[i] = 0;
      end else begin
        if (m_raw[i]) begin
          if ((req || m_pend[i]) && (m_arm[i] || pwm_tick)) begin
            m_raw[i] = 0; m_pend[i] = 0;
          end else if (req) m_pend[i] = 1;
        end
        m_arm[i] = m_arm[i] || pwm_tick;
      end
    end
    if (wr_en && addr == EN) m_en = wdata[5:0];
  endtask

  task automatic step(input logic [5:0] e, input bit t, input bit w,
                      input logic [11:0] a, input logic [31:0] d);
    evt = e; pwm_tick = t; wr_en = w; addr = a; wdata = d;
    @(posedge clk);
    model_update();
    @(negedge clk);
    chk({31'd0, irq}, {31'd0, |(raw_vec() & m_en)}, "R4 irq vs model");
    chk(rdata, exp_read(addr), "R3 rdata vs model");
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    evt = '0; wr_en = 0; pwm_tick = 0; addr = a;
    #1;
    chk(rdata, exp, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(ST, 0, "R1 status after reset");
    rd(RW, 0, "R1 raw after reset");
    rd(EN, 0, "R1 enable after reset");
    chk({31'd0, irq}, 0, "R1 irq after reset");

    step(6'h01, 1, 0, RW, 0);
    step(0, 0, 0, RW, 0);
    rd(RW, 32'h1, "R2 raw sticky with enable off");
    rd(ST, 32'h0, "R3 masked zero while disabled");
    chk({31'd0, irq}, 0, "R4 irq low while disabled");

    step(0, 0, 1, EN, 32'hFFFF_FFFF);
    rd(ST, 32'h1, "R3 masked after enable");
    chk({31'd0, irq}, 1, "R4 irq high");

    step(0, 0, 1, ST, 32'h0);
    rd(RW, 32'h1, "R5 write of zero leaves bit");

    step(0, 0, 1, ST, 32'h1);
    rd(RW, 32'h1, "R6 early clear held pending");
    step(0, 0, 0, RW, 0);
    rd(RW, 32'h1, "R6 still pending without tick");
    step(0, 1, 0, RW, 0);
    rd(RW, 32'h0, "R6 pending clear applied at tick");
    chk({31'd0, irq}, 0, "R4 irq low after clear");

    step(6'h04, 1, 0, RW, 0);
    step(0, 1, 0, RW, 0);
    step(0, 0, 1, ST, 32'h4);
    rd(RW, 32'h0, "R5 armed clear immediate");

    step(6'h08, 1, 0, RW, 0);
    step(0, 1, 0, RW, 0);
    step(6'h08, 0, 1, ST, 32'h8);
    rd(RW, 32'h8, "R7 set wins over clear");

    step(0, 0, 1, RW, 32'hFF);
    rd(RW, 32'h8, "R8 raw write ignored");
    step(0, 0, 1, EN, 32'hFFFF_FFC5);
    rd(EN, 32'h5, "R8 enable stores low bits");
    rd(12'h000, 32'h0, "R3 unknown offset reads zero");
    rd(ST, 32'h0, "R3 masked hides disabled bit");

    for (int n = 0; n < 400; n++) begin
      logic [11:0] a;
      int s;
      s = $urandom % 3;
      a = (s == 0) ? ST : (s == 1) ? RW : EN;
      step(($urandom % 3 == 0) ? 6'($urandom) : 6'h0, ($urandom % 4 == 0),
           ($urandom % 3 == 0), a, $urandom);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule